// File: doc/BRIEF.md
# Clock Page Replacement Selector

This block tracks the residency state of a fixed set of memory frames and picks which frame to evict when a new page has to be brought in. For every frame it holds a valid bit, a reference bit and a dirty bit. A circular hand points at one frame. An access port records reads and writes. A fill port marks a frame as freshly loaded.

A victim search starts with a one-cycle request pulse. If any frame is still empty, the lowest-numbered empty frame is returned at once. Otherwise the hand sweeps one frame per cycle. A frame whose reference bit is set gets a second chance: the bit is cleared and the hand moves on. The first frame found with a clear bit becomes the victim. The response pulse carries the chosen frame number and a flag that tells the caller whether the frame holds modified data that must be written back before reuse. Page-table lookup and the data movement itself belong to the surrounding logic.

Top module: `clock_repl_sel`

## Requirements
- R1: An access sets the reference bit of the addressed frame at the next clock edge. If the write flag is high, it also sets that frame's dirty bit.
- R2: A fill makes the addressed frame valid, sets its reference bit and clears its dirty bit. A frame filled after being chosen is therefore passed over once by the next sweep.
- R3: When a request is accepted and at least one frame is invalid, the lowest-numbered invalid frame is returned. The response pulse comes one cycle after the request, and the hand does not move.
- R4: When all frames are valid, the sweep examines the frame under the hand once per cycle, starting in the cycle after the request. A frame with its reference bit set has that bit cleared, and the hand advances to the next frame, wrapping from the last frame to frame 0.
- R5: The first swept frame with a clear reference bit is returned. The response comes k+2 cycles after the request, where k is the number of frames skipped, and the hand is left one frame past the victim.
- R6: The write-back flag returned with the victim equals that frame's dirty bit. A write access to the same frame in the cycle the choice is made also counts as dirty.
- R7: Once the sweep has cleared NFRAMES reference bits, the frame under the hand is taken regardless of its bit. The response therefore never comes later than NFRAMES+2 cycles after the request.
- R8: When an access and a sweep clear hit the same frame in the same cycle, the reference bit ends up set.
- R9: A request that arrives while a sweep is in progress (busy high) is ignored and produces no extra response.
- R10: After reset all frames are invalid, with clear reference and dirty bits, the hand is at frame 0, and busy and the response pulse are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | An access to a frame happens this cycle |
| acc_frame | input | IDX_W | Frame number of the access |
| acc_write | input | 1 | The access is a write |
| vic_req | input | 1 | Victim search request pulse |
| vic_busy | output | 1 | A sweep is in progress; requests are ignored |
| vic_done | output | 1 | One-cycle pulse: victim result is valid |
| vic_frame | output | IDX_W | Chosen frame number |
| vic_wb | output | 1 | Chosen frame needs write-back |
| fill_valid | input | 1 | A frame is loaded this cycle |
| fill_frame | input | IDX_W | Frame number of the fill |

## Verification
Bit updates from an access or a fill take effect at the next edge. A response is due one edge after the request when an empty frame exists, and k+2 edges after it when the sweep skips k frames. The bench drives every input on the falling edge. After each rising edge it samples the response on the following falling edge and counts edges from the request, so the expected latency in each vector is compared exactly. Effects on the bits, which cannot be seen at the ports directly, are checked through the frame and latency of a later search.

// File: rtl/clock_repl_pkg.sv
// Package: shared types for the clock replacement selector.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package clock_repl_pkg;
    // Sweep controller state
    typedef enum logic {
        HAND_IDLE  = 1'b0,
        HAND_SWEEP = 1'b1
    } hand_state_e;
endpackage

// File: rtl/frame_state_bits.sv
// Module: frame_state_bits
// Holds valid, reference and dirty bits for every frame and applies
// access, fill and sweep-clear updates.
// Assumes: at most one access, one fill and one clear per cycle.
// An access outranks a clear on the reference bit; a write access
// outranks a fill on the dirty bit.
module frame_state_bits #(
    parameter int NFRAMES = 8,
    parameter int IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic [IDX_W-1:0]   acc_frame,
    input  logic               acc_write,
    input  logic               fill_valid,
    input  logic [IDX_W-1:0]   fill_frame,
    input  logic               clr_en,
    input  logic [IDX_W-1:0]   clr_idx,
    output logic [NFRAMES-1:0] valid_vec,
    output logic [NFRAMES-1:0] refb_vec,
    output logic [NFRAMES-1:0] dirty_vec,
    output logic [NFRAMES-1:0] dirty_eff
);
    for (genvar i = 0; i < NFRAMES; i++) begin : g_frame
        logic hit_acc, hit_fill, hit_clr;

        // Decode which requests address this frame
        always_comb begin
            hit_acc  = acc_valid  && (acc_frame  == IDX_W'(i));
            hit_fill = fill_valid && (fill_frame == IDX_W'(i));
            hit_clr  = clr_en     && (clr_idx    == IDX_W'(i));
        end

        // Reference bit: set by access or fill, cleared by the sweep
        always_ff @(posedge clk) begin
            if (!rst_n)                   refb_vec[i] <= 1'b0;
            else if (hit_acc || hit_fill) refb_vec[i] <= 1'b1;
            else if (hit_clr)             refb_vec[i] <= 1'b0;
        end

        // Dirty bit: set by a write access, cleared by a fill
        always_ff @(posedge clk) begin
            if (!rst_n)                      dirty_vec[i] <= 1'b0;
            else if (hit_acc && acc_write)   dirty_vec[i] <= 1'b1;
            else if (hit_fill)               dirty_vec[i] <= 1'b0;
        end

        // Valid bit: set once the frame has been filled
        always_ff @(posedge clk) begin
            if (!rst_n)        valid_vec[i] <= 1'b0;
            else if (hit_fill) valid_vec[i] <= 1'b1;
        end

        // Dirty as seen this cycle, counting a write in flight
        always_comb dirty_eff[i] = dirty_vec[i] | (hit_acc & acc_write);
    end
endmodule

// File: rtl/empty_frame_finder.sv
// Module: empty_frame_finder
// Priority encoder that finds the lowest-numbered invalid frame.
// Assumes: purely combinational; the index is meaningless when found=0.
module empty_frame_finder #(
    parameter int NFRAMES = 8,
    parameter int IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input  logic [NFRAMES-1:0] valid_vec,
    output logic               found,
    output logic [IDX_W-1:0]   idx
);
    // Scan from the top down so the lowest index is the one kept
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NFRAMES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/clock_hand_ctrl.sv
// Module: clock_hand_ctrl
// Owns the circular hand and runs the victim search: an empty frame
// is taken at once, otherwise one frame is examined per cycle with
// second-chance clearing and a forced choice after NFRAMES clears.
// Assumes: requests are pulses; they are ignored during a sweep.
module clock_hand_ctrl
    import clock_repl_pkg::*;
#(
    parameter int NFRAMES = 8,
    parameter int IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [NFRAMES-1:0] refb_vec,
    input  logic [NFRAMES-1:0] dirty_eff,
    input  logic               any_empty,
    input  logic [IDX_W-1:0]   empty_idx,
    output logic               clr_en,
    output logic [IDX_W-1:0]   clr_idx,
    output logic               busy,
    output logic               done,
    output logic [IDX_W-1:0]   vic_frame,
    output logic               vic_wb,
    output logic [IDX_W-1:0]   hand
);
    localparam int              CNT_W  = $clog2(NFRAMES + 1);
    localparam logic [IDX_W-1:0] LAST  = IDX_W'(NFRAMES - 1);
    localparam logic [CNT_W-1:0] LIMIT = CNT_W'(NFRAMES);

    hand_state_e      state_q;
    logic [IDX_W-1:0] hand_q, hand_nxt, frame_q;
    logic [CNT_W-1:0] cnt_q;
    logic             done_q, wb_q, take;

    // Decide this cycle's sweep action at the hand position
    always_comb begin
        hand_nxt = (hand_q == LAST) ? '0 : hand_q + 1'b1;
        take     = (state_q == HAND_SWEEP) &&
                   (!refb_vec[hand_q] || (cnt_q == LIMIT));
        clr_en   = (state_q == HAND_SWEEP) && !take;
        clr_idx  = hand_q;
    end

    // Search state machine, hand pointer and registered result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= HAND_IDLE;
            hand_q  <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            frame_q <= '0;
            wb_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                HAND_IDLE: begin
                    if (req) begin
                        if (any_empty) begin
                            done_q  <= 1'b1;
                            frame_q <= empty_idx;
                            wb_q    <= dirty_eff[empty_idx];
                        end else begin
                            state_q <= HAND_SWEEP;
                            cnt_q   <= '0;
                        end
                    end
                end
                HAND_SWEEP: begin
                    hand_q <= hand_nxt;
                    if (take) begin
                        done_q  <= 1'b1;
                        frame_q <= hand_q;
                        wb_q    <= dirty_eff[hand_q];
                        state_q <= HAND_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= HAND_IDLE;
            endcase
        end
    end

    // Drive the outputs from registers
    always_comb begin
        busy      = (state_q == HAND_SWEEP);
        done      = done_q;
        vic_frame = frame_q;
        vic_wb    = wb_q;
        hand      = hand_q;
    end
endmodule

// File: rtl/clock_repl_sel.sv
// Module: clock_repl_sel (top)
// Clock page replacement selector: per-frame bits, empty-frame finder
// and the hand controller wired together.
// Assumes: fill and access frame numbers are below NFRAMES.
module clock_repl_sel #(
    parameter int NFRAMES = 8,
    parameter int IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic [IDX_W-1:0] acc_frame,
    input  logic             acc_write,
    input  logic             vic_req,
    output logic             vic_busy,
    output logic             vic_done,
    output logic [IDX_W-1:0] vic_frame,
    output logic             vic_wb,
    input  logic             fill_valid,
    input  logic [IDX_W-1:0] fill_frame
);
    logic [NFRAMES-1:0] valid_vec, refb_vec, dirty_vec, dirty_eff;
    logic               clr_en, any_empty;
    logic [IDX_W-1:0]   clr_idx, empty_idx, hand;

    frame_state_bits #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) bits_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
        .fill_valid(fill_valid), .fill_frame(fill_frame),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .valid_vec(valid_vec), .refb_vec(refb_vec),
        .dirty_vec(dirty_vec), .dirty_eff(dirty_eff)
    );

    empty_frame_finder #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) find_i (
        .valid_vec(valid_vec), .found(any_empty), .idx(empty_idx)
    );

    clock_hand_ctrl #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) hand_i (
        .clk(clk), .rst_n(rst_n), .req(vic_req),
        .refb_vec(refb_vec), .dirty_eff(dirty_eff),
        .any_empty(any_empty), .empty_idx(empty_idx),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .busy(vic_busy), .done(vic_done),
        .vic_frame(vic_frame), .vic_wb(vic_wb), .hand(hand)
    );
endmodule

// File: rtl/clock_repl_sel_chk.sv
// Module: clock_repl_sel_chk
// Property checker bound into clock_repl_sel; watches ports and the
// frame bit vectors.
// Assumes: synchronous active-low reset shared with the design.
module clock_repl_sel_chk #(
    parameter int NFRAMES = 8,
    parameter int IDX_W   = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic [IDX_W-1:0]   acc_frame,
    input logic               acc_write,
    input logic               fill_valid,
    input logic [IDX_W-1:0]   fill_frame,
    input logic               vic_busy,
    input logic               vic_done,
    input logic [IDX_W-1:0]   vic_frame,
    input logic [IDX_W-1:0]   hand,
    input logic [NFRAMES-1:0] valid_vec,
    input logic [NFRAMES-1:0] refb_vec,
    input logic [NFRAMES-1:0] dirty_vec
);
    localparam int              RUN_W = $clog2(NFRAMES + 2);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NFRAMES - 1);

    logic [RUN_W-1:0] run_q;

    // Count consecutive busy cycles for the sweep bound
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (vic_busy) run_q <= run_q + 1'b1;
        else               run_q <= '0;
    end

    AST_ACC_SETS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> refb_vec[$past(acc_frame)]); // R1

    AST_WRITE_SETS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_write |=> dirty_vec[$past(acc_frame)]); // R1

    AST_FILL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid && !(acc_valid && acc_frame == fill_frame)
        |=> valid_vec[$past(fill_frame)] && refb_vec[$past(fill_frame)]
            && !dirty_vec[$past(fill_frame)]); // R2

    AST_EMPTY_PICK_HAND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        vic_done && !$past(vic_busy) |-> $stable(hand)); // R3

    AST_HAND_PAST_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
        vic_done && $past(vic_busy)
        |-> hand == ((vic_frame == LAST) ? '0 : vic_frame + 1'b1)); // R5

    AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        vic_busy |-> run_q <= RUN_W'(NFRAMES)); // R7

    AST_DONE_ENDS_SWEEP: assert property (@(posedge clk) disable iff (!rst_n)
        vic_done |-> !vic_busy); // R9
endmodule

bind clock_repl_sel clock_repl_sel_chk #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) chk_i (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
    .fill_valid(fill_valid), .fill_frame(fill_frame),
    .vic_busy(vic_busy), .vic_done(vic_done), .vic_frame(vic_frame),
    .hand(hand), .valid_vec(valid_vec), .refb_vec(refb_vec),
    .dirty_vec(dirty_vec)
);

// File: tb/clock_repl_sel_tb_top.sv
// Bench: vector table walk followed by directed corner-case tests.
module clock_repl_sel_tb_top;
    localparam int NF = 4;
    localparam int IW = 2;

    // Vector fields: op(2) frame(2) wr(1) exp_frame(2) exp_wb(1) exp_lat(4)
    // op: 0 = access, 1 = fill, 2 = victim request
    localparam int NVEC = 19;
    localparam logic [11:0] VEC [NVEC] = '{
        {2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 4'd1},  // R3 empty frame 0
        {2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 4'd0},
        {2'd2, 2'd0, 1'b0, 2'd1, 1'b0, 4'd1},  // R3
        {2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 4'd0},
        {2'd2, 2'd0, 1'b0, 2'd2, 1'b0, 4'd1},  // R3
        {2'd1, 2'd2, 1'b0, 2'd0, 1'b0, 4'd0},
        {2'd2, 2'd0, 1'b0, 2'd3, 1'b0, 4'd1},  // R3
        {2'd1, 2'd3, 1'b0, 2'd0, 1'b0, 4'd0},
        {2'd0, 2'd2, 1'b1, 2'd0, 1'b0, 4'd0},  // R1 write
        {2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 4'd6},  // R4 full sweep with wrap
        {2'd1, 2'd0, 1'b0, 2'd0, 1'b0, 4'd0},
        {2'd2, 2'd0, 1'b0, 2'd1, 1'b0, 4'd2},  // R5
        {2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 4'd0},
        {2'd2, 2'd0, 1'b0, 2'd2, 1'b1, 4'd2},  // R6 dirty victim
        {2'd1, 2'd2, 1'b0, 2'd0, 1'b0, 4'd0},
        {2'd0, 2'd3, 1'b1, 2'd0, 1'b0, 4'd0},
        {2'd2, 2'd0, 1'b0, 2'd3, 1'b1, 4'd6},  // R2 filled frames skipped
        {2'd1, 2'd3, 1'b0, 2'd0, 1'b0, 4'd0},
        {2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 4'd2}   // R2 fill cleared dirty
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0, acc_write = 1'b0;
    logic [IW-1:0] acc_frame = '0;
    logic          vic_req = 1'b0;
    logic          vic_busy, vic_done, vic_wb;
    logic [IW-1:0] vic_frame;
    logic          fill_valid = 1'b0;
    logic [IW-1:0] fill_frame = '0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    clock_repl_sel #(.NFRAMES(NF), .IDX_W(IW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_frame(acc_frame), .acc_write(acc_write),
        .vic_req(vic_req), .vic_busy(vic_busy), .vic_done(vic_done),
        .vic_frame(vic_frame), .vic_wb(vic_wb),
        .fill_valid(fill_valid), .fill_frame(fill_frame)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        acc_valid = 1'b0; vic_req = 1'b0; fill_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic do_fill(input int f);
        fill_valid = 1'b1; fill_frame = IW'(f);
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    task automatic do_acc(input int f, input bit wr);
        acc_valid = 1'b1; acc_frame = IW'(f); acc_write = wr;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    // Pulse a request and count edges until the response
    task automatic do_req(input string req, input int ef, input int ewb, input int elat);
        int lat;
        vic_req = 1'b1;
        @(negedge clk);
        vic_req = 1'b0;
        lat = 1;
        while (!vic_done && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        check(lat == elat, req, lat, elat);
        check(vic_frame == IW'(ef), req, int'(vic_frame), ef);
        check(vic_wb == ewb[0], req, int'(vic_wb), ewb);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int lat;
        int seen;
        do_reset();
        // R10 reset state
        check(vic_done == 1'b0, "R10 done", int'(vic_done), 0);
        check(vic_busy == 1'b0, "R10 busy", int'(vic_busy), 0);

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][11:10])
                2'd0: do_acc(int'(VEC[i][9:8]), VEC[i][7]);
                2'd1: do_fill(int'(VEC[i][9:8]));
                default: do_req($sformatf("R5 vector %0d", i), int'(VEC[i][6:5]),
                                int'(VEC[i][4]), int'(VEC[i][3:0]));
            endcase
        end

        // R9: a second request during a sweep is ignored
        do_reset();
        for (int f = 0; f < NF; f++) do_fill(f);
        vic_req = 1'b1;
        @(negedge clk);
        vic_req = 1'b0;
        check(vic_busy == 1'b1, "R9 busy", int'(vic_busy), 1);
        vic_req = 1'b1;
        @(negedge clk);
        vic_req = 1'b0;
        seen = 0;
        for (int c = 0; c < 14; c++) begin
            if (vic_done) seen++;
            @(negedge clk);
        end
        check(seen == 1, "R9 responses", seen, 1);
        check(vic_busy == 1'b0, "R9 idle", int'(vic_busy), 0);

        // R7 and R8: accesses on the hand frame every sweep cycle
        do_reset();
        for (int f = 0; f < NF; f++) do_fill(f);
        vic_req = 1'b1;
        @(negedge clk);
        vic_req = 1'b0;
        lat = 1;
        for (int k = 0; k <= NF && !vic_done; k++) begin
            acc_valid = 1'b1; acc_frame = IW'(k % NF); acc_write = 1'b0;
            @(negedge clk);
            lat++;
        end
        acc_valid = 1'b0;
        check(vic_done == 1'b1, "R7 forced done", int'(vic_done), 1);
        check(lat == NF + 2, "R7 latency", lat, NF + 2);
        check(vic_frame == 2'd0, "R7 frame", int'(vic_frame), 0);
        // Reference bits survived the clears, so the next search sweeps fully
        do_req("R8 access beats clear", 1, 0, NF + 2);

        // R6: write in the choice cycle marks the victim for write-back
        do_reset();
        acc_valid = 1'b1; acc_frame = 2'd0; acc_write = 1'b1;
        do_req("R6 write in choice cycle", 0, 1, 1);
        acc_valid = 1'b0; acc_write = 1'b0;

        // R10: reset after activity restores empty frames
        for (int f = 0; f < NF; f++) do_fill(f);
        do_reset();
        check(vic_done == 1'b0, "R10 done after reset", int'(vic_done), 0);
        do_req("R10 empty after reset", 0, 0, 1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule